// File: doc/BRIEF.md
# Frequency Lock Monitor with Reference Supervision

This block raises a loss-of-lock alarm for a clock-recovery loop. It watches two incoming clocks, the system reference and a divided copy of the recovered clock, from a free-running local monitor clock. Both are synchronised into the monitor domain and their rising edges are counted. A measurement window spans a fixed power-of-two number of reference periods, and the recovered-clock edges seen in that window give the frequency ratio. The error against the nominal ratio, in parts per million, feeds a two-state lock tracker. The tracker has separate thresholds for leaving and for re-entering lock.

The nominal ratio depends on two things. One is the selected line rate, given by a select input. The other is which of three reference frequencies is applied, and the block works that out from each window's count without any configuration. A watchdog on the monitor clock forces the alarm high when the reference stops toggling. A powerdown input masks the alarm and holds the monitor in its initial state.

Top module: `lfd_lock_monitor`

## Requirements
- R1: After reset, with `pwrdn` low, `lol` is high (unlocked) until a measurement window proves lock.
- R2: A window starts at the first synchronised reference rising edge after a restart and ends 2^WIN_LOG2 reference rising edges later. The lock state changes only at a window end, or to unlocked on a restart. After a restart `lol` therefore stays high for at least one full window.
- R3: While locked, a window whose frequency error is strictly above OUT_PPM makes `lol` go high.
- R4: While unlocked, a window whose frequency error is strictly below IN_PPM makes `lol` go low.
- R5: A window whose error lies between IN_PPM and OUT_PPM leaves the lock state unchanged (hysteresis).
- R6: Frequency error is |M - E| / E in ppm. M is the window's divided-clock edge count times 2^PRE_LOG2. E is 2^WIN_LOG2 * 2^t, where t = 5 for `rate_sel`=0 or 3 for `rate_sel`=1, less 0, 2 or 3 for a reference of 19.44, 77.76 or 155.52 MHz. The reference is the candidate whose E is nearest in ratio: reference 0 if M >= E0/2, else reference 1 if M >= 0.75*E1, else reference 2.
- R7: `rate_sel`=0 selects the 622.08 Mb/s line rate and `rate_sel`=1 selects 155.52 Mb/s. A change of `rate_sel` restarts the window and clears lock.
- R8: When REF_TIMEOUT monitor cycles pass with no reference rising edge, `lol` goes high at once and lock is cleared. Lock returns only through a complete new window.
- R9: `lol` is low in every cycle in which `pwrdn` is high. While `pwrdn` is high the monitor is held unlocked, so `lol` is high right after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_clk | input | 1 | Local monitor clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, sampled as data |
| div_clk | input | 1 | Divided recovered clock, sampled as data |
| rate_sel | input | 1 | Line-rate select: 0 = 622.08 Mb/s, 1 = 155.52 Mb/s |
| pwrdn | input | 1 | Powerdown: masks the alarm and holds the monitor unlocked |
| lol | output | 1 | Loss-of-lock alarm, high = not locked or reference missing |

## Verification
The assertions check the per-cycle rules on every cycle. These are the powerdown mask, the alarm forced by a missing reference, and the watchdog being cleared by each reference edge. They also check that lock changes only at a window end or a restart, and that each window end moves the tracker the way its threshold flags demand. Only the bench scenarios can show that the measured error, the rate classification and the hysteresis band match real clock ratios. They sweep every line-rate and reference combination with clean and offset recovered clocks, step the offset through the band, and time the relock after the reference returns.

// File: rtl/lfd_pkg.sv
`timescale 1ps/1ps
package lfd_pkg;

  typedef enum logic {LK_HUNT = 1'b0, LK_HELD = 1'b1} lock_state_e;
  typedef logic [63:0] wide_t;

  localparam wide_t PPM_SCALE = 64'd1000000;

  // Log2 of the nominal divided-clock to reference ratio (times 2^PRE_LOG2).
  function automatic int unsigned rate_shift(input logic rsel, input logic [1:0] ridx);
    int unsigned base;
    int unsigned drop;
    base = rsel ? 32'd3 : 32'd5;
    case (ridx)
      2'd0:    drop = 32'd0;
      2'd1:    drop = 32'd2;
      default: drop = 32'd3;
    endcase
    return base - drop;
  endfunction

  // Nearest-ratio decision among the three reference candidates.
  function automatic logic [1:0] classify_ref(input wide_t meas, input wide_t span,
                                              input logic rsel);
    int unsigned t0;
    wide_t       cut01;
    wide_t       cut12;
    t0    = rsel ? 32'd3 : 32'd5;
    cut01 = span << (t0 - 32'd1);
    cut12 = ((span * 64'd3) << t0) >> 4;
    if (meas >= cut01)      return 2'd0;
    else if (meas >= cut12) return 2'd1;
    return 2'd2;
  endfunction

  function automatic wide_t abs_diff(input wide_t a, input wide_t b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // Error strictly above the given ppm limit.
  function automatic logic ppm_above(input wide_t meas, input wide_t expct,
                                     input int unsigned ppm);
    return (abs_diff(meas, expct) * PPM_SCALE) > (expct * 64'(ppm));
  endfunction

  // Error strictly below the given ppm limit.
  function automatic logic ppm_below(input wide_t meas, input wide_t expct,
                                     input int unsigned ppm);
    return (abs_diff(meas, expct) * PPM_SCALE) < (expct * 64'(ppm));
  endfunction

endpackage

// File: rtl/lfd_sync_bank.sv
`timescale 1ps/1ps
module lfd_sync_bank #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], async_in[g]};
      end
      assign level[g] = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lfd_ref_watch.sv
`timescale 1ps/1ps
module lfd_ref_watch #(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  output logic ref_lost
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle <= '0;
    else if (ref_rise)       idle <= '0;
    else if (idle != LIMIT)  idle <= idle + 1'b1;
  end

  assign ref_lost = (idle == LIMIT);
endmodule

// File: rtl/lfd_window_cnt.sv
`timescale 1ps/1ps
module lfd_window_cnt #(
  parameter int unsigned WIN_LOG2 = 16,
  parameter int unsigned CNT_W    = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             ref_rise,
  input  logic             div_rise,
  output logic             win_done,
  output logic [CNT_W-1:0] win_count
);
  localparam logic [WIN_LOG2-1:0] LAST = '1;
  localparam logic [CNT_W-1:0]    CMAX = '1;

  logic                armed;
  logic [WIN_LOG2-1:0] ref_cnt;
  logic [CNT_W-1:0]    div_cnt;
  logic [CNT_W-1:0]    div_next;

  assign div_next  = (div_rise && div_cnt != CMAX) ? div_cnt + 1'b1 : div_cnt;
  assign win_done  = armed && ref_rise && (ref_cnt == LAST) && !restart;
  assign win_count = div_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      ref_cnt <= '0;
      div_cnt <= '0;
    end else if (restart) begin
      armed   <= 1'b0;
      ref_cnt <= '0;
      div_cnt <= '0;
    end else if (!armed) begin
      if (ref_rise) begin
        armed   <= 1'b1;
        ref_cnt <= '0;
        div_cnt <= '0;
      end
    end else if (ref_rise) begin
      ref_cnt <= ref_cnt + 1'b1;
      div_cnt <= (ref_cnt == LAST) ? '0 : div_next;
    end else begin
      div_cnt <= div_next;
    end
  end
endmodule

// File: rtl/lfd_lock_fsm.sv
`timescale 1ps/1ps
module lfd_lock_fsm
  import lfd_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 16,
  parameter int unsigned PRE_LOG2 = 4,
  parameter int unsigned CNT_W    = 23,
  parameter int unsigned OUT_PPM  = 600,
  parameter int unsigned IN_PPM   = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             win_done,
  input  logic [CNT_W-1:0] win_count,
  input  logic             rsel,
  output logic             locked,
  output logic             beyond_out,
  output logic             within_in
);
  localparam wide_t SPAN = 64'd1 << WIN_LOG2;

  lock_state_e state;
  wide_t       meas;
  wide_t       expct;
  logic [1:0]  ref_idx;

  assign meas       = wide_t'(win_count) << PRE_LOG2;
  assign ref_idx    = classify_ref(meas, SPAN, rsel);
  assign expct      = SPAN << rate_shift(rsel, ref_idx);
  assign beyond_out = ppm_above(meas, expct, OUT_PPM);
  assign within_in  = ppm_below(meas, expct, IN_PPM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state <= LK_HUNT;
    else if (restart)    state <= LK_HUNT;
    else if (win_done) begin
      case (state)
        LK_HELD: if (beyond_out) state <= LK_HUNT;
        default: if (within_in)  state <= LK_HELD;
      endcase
    end
  end

  assign locked = (state == LK_HELD);
endmodule

// File: rtl/lfd_lock_monitor.sv
`timescale 1ps/1ps
module lfd_lock_monitor #(
  parameter int unsigned WIN_LOG2    = 16,
  parameter int unsigned PRE_LOG2    = 4,
  parameter int unsigned OUT_PPM     = 600,
  parameter int unsigned IN_PPM      = 300,
  parameter int unsigned REF_TIMEOUT = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic div_clk,
  input  logic rate_sel,
  input  logic pwrdn,
  output logic lol
);
  localparam int unsigned CNT_W = WIN_LOG2 + 7;

  logic [3:0]       lvl;
  logic             ref_q, div_q, rsel_q;
  logic             ref_rise, div_rise, pwrdn_s, rsel_s, rsel_chg;
  logic             ref_lost, restart, win_done, locked;
  logic             beyond_out, within_in;
  logic [CNT_W-1:0] win_count;

  lfd_sync_bank #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(mon_clk), .rst_n(rst_n),
    .async_in({rate_sel, pwrdn, div_clk, ref_clk}),
    .level(lvl)
  );

  assign pwrdn_s = lvl[2];
  assign rsel_s  = lvl[3];

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      div_q  <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      ref_q  <= lvl[0];
      div_q  <= lvl[1];
      rsel_q <= rsel_s;
    end
  end

  assign ref_rise = lvl[0] & ~ref_q;
  assign div_rise = lvl[1] & ~div_q;
  assign rsel_chg = rsel_s ^ rsel_q;
  assign restart  = pwrdn_s | ref_lost | rsel_chg;

  lfd_ref_watch #(.TIMEOUT(REF_TIMEOUT)) u_watch (
    .clk(mon_clk), .rst_n(rst_n), .ref_rise(ref_rise), .ref_lost(ref_lost)
  );

  lfd_window_cnt #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_win (
    .clk(mon_clk), .rst_n(rst_n), .restart(restart),
    .ref_rise(ref_rise), .div_rise(div_rise),
    .win_done(win_done), .win_count(win_count)
  );

  lfd_lock_fsm #(.WIN_LOG2(WIN_LOG2), .PRE_LOG2(PRE_LOG2), .CNT_W(CNT_W),
                 .OUT_PPM(OUT_PPM), .IN_PPM(IN_PPM)) u_fsm (
    .clk(mon_clk), .rst_n(rst_n), .restart(restart),
    .win_done(win_done), .win_count(win_count), .rsel(rsel_s),
    .locked(locked), .beyond_out(beyond_out), .within_in(within_in)
  );

  assign lol = ~pwrdn & (ref_lost | ~locked);
endmodule

// File: rtl/lfd_lock_monitor_chk.sv
`timescale 1ps/1ps
module lfd_lock_monitor_chk (
  input logic mon_clk,
  input logic rst_n,
  input logic pwrdn,
  input logic lol,
  input logic ref_rise,
  input logic ref_lost,
  input logic win_done,
  input logic restart,
  input logic locked,
  input logic beyond_out,
  input logic within_in
);
  AST_PWRDN_QUIET: assert property (@(posedge mon_clk) disable iff (!rst_n)
    pwrdn |-> !lol); // R9
  AST_LOST_ALARM: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (ref_lost && !pwrdn) |-> lol); // R8
  AST_LOST_DROPS: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $rose(ref_lost) |=> !locked); // R8
  AST_EDGE_FEEDS_WATCH: assert property (@(posedge mon_clk) disable iff (!rst_n)
    ref_rise |=> !ref_lost); // R8
  AST_LOCK_AT_WINDOW: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $rose(locked) |-> $past(win_done)); // R2
  AST_UNLOCK_CAUSE: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $fell(locked) |-> $past(win_done || restart)); // R2
  AST_EXIT_LOCK: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (win_done && locked && beyond_out) |=> !locked); // R3
  AST_ENTER_LOCK: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (win_done && !locked && within_in) |=> locked); // R4
  AST_HOLD_BAND: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (win_done && !beyond_out && !within_in) |=> (locked == $past(locked))); // R5
endmodule

bind lfd_lock_monitor lfd_lock_monitor_chk chk_i (
  .mon_clk(mon_clk), .rst_n(rst_n), .pwrdn(pwrdn), .lol(lol),
  .ref_rise(ref_rise), .ref_lost(ref_lost), .win_done(win_done),
  .restart(restart), .locked(locked),
  .beyond_out(beyond_out), .within_in(within_in)
);

// File: tb/lfd_lock_monitor_tb_top.sv
`timescale 1ps/1ps
module lfd_lock_monitor_tb_top;
  localparam int unsigned WIN_LOG2 = 7;
  localparam int unsigned PRE_LOG2 = 2;
  localparam int unsigned OUT_PPM  = 150000;
  localparam int unsigned IN_PPM   = 75000;
  localparam int unsigned TMO      = 64;
  localparam longint     WIN      = 64'd1 << WIN_LOG2;

  logic mon_clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, div_clk = 1'b0;
  logic rate_sel = 1'b0, pwrdn = 1'b0;
  logic lol;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit ref_run = 1'b1;
  int ref_period = 20000, ref_half = 10000, div_half = 10000;
  bit exp_lk = 1'b0;

  lfd_lock_monitor #(.WIN_LOG2(WIN_LOG2), .PRE_LOG2(PRE_LOG2), .OUT_PPM(OUT_PPM),
                     .IN_PPM(IN_PPM), .REF_TIMEOUT(TMO), .SYNC_STAGES(2)) dut_i (
    .mon_clk(mon_clk), .rst_n(rst_n), .ref_clk(ref_clk), .div_clk(div_clk),
    .rate_sel(rate_sel), .pwrdn(pwrdn), .lol(lol)
  );

  always #2500 mon_clk = ~mon_clk;

  initial begin
    #1300;
    forever begin
      if (ref_run) begin #(ref_half) ref_clk = ~ref_clk; end
      else begin ref_clk = 1'b0; #2500; end
    end
  end

  initial begin
    #700;
    forever begin #(div_half) div_clk = ~div_clk; end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: lol actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Reference periods follow 19.44 / 77.76 / 155.52 MHz scaled; divided clock
  // nominal is 4x (rate 0) or 1x (rate 1) the 155.52 MHz reference rate / 2^PRE_LOG2 * 4.
  task automatic set_clk(input int ridx, input int sel, input int off_pm);
    int nom;
    ref_period = (ridx == 0) ? 160000 : (ridx == 1) ? 40000 : 20000;
    ref_half   = ref_period / 2;
    rate_sel   = sel[0];
    nom        = (sel != 0) ? 80000 : 20000;
    div_half   = (nom * 1000 / (1000 + off_pm)) / 2;
  endtask

  function automatic bit next_lock(input bit prev, input int off_pm);
    longint err;
    err = (off_pm < 0 ? -off_pm : off_pm) * 1000;
    if (err < IN_PPM)  return 1'b1;
    if (err > OUT_PPM) return 1'b0;
    return prev;
  endfunction

  task automatic wait_win(input int n);
    #(longint'(n) * WIN * ref_period);
    @(negedge mon_clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge mon_clk);
  endtask

  task automatic step(input string req, input string what, input int ridx, input int sel,
                      input int off_pm);
    set_clk(ridx, sel, off_pm);
    exp_lk = next_lock(exp_lk, off_pm);
    wait_win(3);
    check(req, what, lol, ~exp_lk);
  endtask

  initial begin
    #(64'd180000 * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_clk(2, 0, 250);
    wait_cyc(10);
    check("R1", "in reset", lol, 1'b1);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R1", "after reset", lol, 1'b1);
    exp_lk = 1'b0;

    // R6 / R3: every line-rate and reference combination, clean then offset
    for (int sel = 0; sel < 2; sel++) begin
      for (int r = 0; r < 3; r++) begin
        step("R6", $sformatf("clean sel=%0d ref=%0d", sel, r), r, sel, 0);
        step("R3", $sformatf("offset sel=%0d ref=%0d", sel, r), r, sel, (r % 2 == 1) ? 250 : -300);
      end
    end

    // R4 / R5 / R3: hysteresis band walk
    step("R4", "enter from clean", 2, 0, 0);
    step("R5", "band while locked", 2, 0, 110);
    step("R3", "far exit", 2, 0, 300);
    step("R5", "band while unlocked", 2, 0, -110);
    step("R4", "re-enter", 2, 0, 0);

    // R7: line-rate change with the divided clock still at the old rate
    rate_sel = 1'b1;
    wait_cyc(20);
    check("R7", "select change clears lock", lol, 1'b1);
    wait_win(3);
    check("R7", "rate 1 against rate 0 clock", lol, 1'b1);
    set_clk(2, 1, 0);
    exp_lk = 1'b1;
    wait_win(3);
    check("R7", "rate 1 clock matched", lol, 1'b0);

    // R8: reference stops
    ref_run = 1'b0;
    wait_cyc(30);
    check("R8", "before timeout", lol, 1'b0);
    wait_cyc(60);
    check("R8", "after timeout", lol, 1'b1);
    pwrdn = 1'b1;
    wait_cyc(3);
    check("R9", "mask over missing reference", lol, 1'b0);
    pwrdn = 1'b0;
    wait_cyc(5);
    check("R9", "release with reference missing", lol, 1'b1);
    ref_run = 1'b1;
    #(longint'(WIN - 3) * ref_period);
    @(negedge mon_clk);
    check("R2", "no lock before first full window", lol, 1'b1);
    #(longint'(9) * ref_period);
    @(negedge mon_clk);
    check("R8", "relock after reference returns", lol, 1'b0);

    // R9: powerdown while locked, then while unlocked
    pwrdn = 1'b1;
    wait_cyc(10);
    check("R9", "mask while locked", lol, 1'b0);
    pwrdn = 1'b0;
    wait_cyc(5);
    check("R9", "release starts unlocked", lol, 1'b1);
    exp_lk = 1'b0;
    step("R4", "lock after release", 2, 1, 0);
    step("R3", "unlock at rate 1", 2, 1, 300);
    pwrdn = 1'b1;
    wait_cyc(3);
    check("R9", "mask while unlocked", lol, 1'b0);
    pwrdn = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule